// File: doc/BRIEF.md
# Sliding-Window SISO Schedule Controller

This controller sequences one half-iteration of a sliding-window soft-in/soft-out decoder. A block of κ windows, each TW trellis stages long, is processed in κ+2 phases of TW cycles. In phase p, symbols of window p are fed from memory in descending stage order, straight into the dummy backward recursion. In the same phase the forward (alpha) recursion runs on window p−1, read ascending from the input buffer, and the backward (beta) recursion with LLR output runs on window p−2, read descending. Once the pipeline is full, three windows are in flight at the same time.

Forward metrics pass to the beta pass through one TW-deep buffer. Its addressing direction flips with phase parity, and each address is read and then rewritten in the same cycle, so the buffer acts as a LIFO without a second bank. The beta recursion of a window loads its start metrics from the final dummy-beta metrics of the next window. The last window takes boundary metrics instead, chosen by a termination mode bit that also governs the dummy recursion on that window. LLR strobes trail the beta steps by a fixed pipeline latency. A done pulse closes the half-iteration, and the controller reports the half-iteration length in cycles. TW and the window limit must be powers of two.

Top module: `sws_ctrl`

## Requirements
- R1: After reset busy_o, done_o, llr_valid_o and every recursion enable are 0, and half_len_o shows the length for κ=1, which is 3·TW+LLR_LAT+1 (99 with the defaults).
- R2: A start_i pulse while busy_o is 0 latches num_win_i, clamped to 1..MAX_WIN (0 becomes 1), and latches term_mode_i. A start_i while busy_o is 1 is ignored and changes neither the schedule nor half_len_o.
- R3: Call the cycle after the start edge step 0, and let p = step/TW. The run lasts (κ+2)·TW steps. feed_en_o is 1 for p<κ. dbeta_en_o is 1 for 1≤p<κ. alpha_en_o is 1 for 1≤p≤κ. beta_en_o is 1 for p≥2.
- R4: feed_idx_o equals p·TW + TW−1−c (c = step mod TW), so each window is fed in descending order.
- R5: alpha_idx_o equals (p−1)·TW + c (ascending). beta_idx_o equals (p−2)·TW + TW−1−c (descending).
- R6: dbeta_init_o pulses in the first cycle of every dummy window. dbeta_term_o is 1 only together with that pulse, for window κ−1, when the latched term mode is 1.
- R7: beta_load_o pulses in the first cycle of every beta window. beta_src_o is 1 (boundary init) only during the beta pass of window κ−1, and 0 (load from dummy-beta result) otherwise.
- R8: The alpha buffer is read before it is written at the same address. Every beta step reads the address that held the alpha value with the same trellis index, and nothing is overwritten before it is read.
- R9: llr_valid_o and llr_idx_o repeat beta_en_o and beta_idx_o after LLR_LAT cycles.
- R10: done_o is a single-cycle pulse one cycle after the last LLR strobe. busy_o is 0 in that cycle, so a new start may be given there.
- R11: half_len_o equals (κ+2)·TW + LLR_LAT + 1 for the latched κ, which is the number of cycles from step 0 through the done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a half-iteration |
| num_win_i | input | 5 | Window count κ |
| term_mode_i | input | 1 | 1: terminated trellis init for the last window |
| busy_o | output | 1 | Half-iteration in progress |
| feed_en_o | output | 1 | Memory feed of current window valid |
| feed_idx_o | output | 9 | Trellis index being fed (and processed by dummy beta) |
| dbeta_en_o | output | 1 | Dummy backward recursion enable |
| dbeta_init_o | output | 1 | Dummy recursion start-metric load |
| dbeta_term_o | output | 1 | Use terminated start metrics with dbeta_init_o |
| alpha_en_o | output | 1 | Forward recursion enable |
| alpha_idx_o | output | 9 | Forward recursion trellis index |
| alpha_wr_addr_o | output | 5 | Alpha buffer write address |
| beta_en_o | output | 1 | Backward recursion enable |
| beta_idx_o | output | 9 | Backward recursion trellis index |
| beta_load_o | output | 1 | Beta start-metric load |
| beta_src_o | output | 1 | Beta start source: 0 dummy result, 1 boundary |
| alpha_rd_addr_o | output | 5 | Alpha buffer read address |
| llr_valid_o | output | 1 | LLR output strobe |
| llr_idx_o | output | 9 | Trellis index of the LLR output |
| done_o | output | 1 | Half-iteration finished |
| half_len_o | output | 10 | Half-iteration length in cycles |

## Verification
The schedule is driven with κ = 1, 2, 3, 5 and 16, with termination mode both on and off. κ=1 exposes the case with no dummy recursion and an immediate boundary beta. κ=2 and 3 show the three-window overlap starting and stopping. κ=16 covers the full index range and many alpha-buffer parity flips. A reference model of the alpha buffer flags any beta read that does not return the matching alpha index. Separate runs cover a start given while busy, plus num_win_i values of 0 and above the limit, to tell clamping apart from plain latching.

// File: rtl/sws_pkg.sv
package sws_pkg;
  typedef enum logic {
    BSRC_DUMMY = 1'b0,
    BSRC_EDGE  = 1'b1
  } beta_src_e;
endpackage

// File: rtl/sws_phase_cnt.sv
module sws_phase_cnt #(
  parameter int TW      = 32,
  parameter int MAX_WIN = 16,
  parameter int SW      = $clog2(TW),
  parameter int KW      = $clog2(MAX_WIN + 1),
  parameter int PW      = $clog2(MAX_WIN + 2)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          busy_i,
  input  logic [KW-1:0] num_win_i,
  input  logic          term_mode_i,
  output logic          active_o,
  output logic [PW-1:0] phase_o,
  output logic [SW-1:0] stage_o,
  output logic [KW-1:0] nwin_o,
  output logic          term_o,
  output logic          last_step_o
);
  localparam int CW = (PW > KW) ? PW : KW;

  logic          active_q, term_q;
  logic [PW-1:0] phase_q;
  logic [SW-1:0] stage_q;
  logic [KW-1:0] nwin_q, nwin_clamp;
  logic          stage_wrap;

  always_comb begin
    if (num_win_i == '0)                   nwin_clamp = KW'(1);
    else if (num_win_i > KW'(MAX_WIN))     nwin_clamp = KW'(MAX_WIN);
    else                                   nwin_clamp = num_win_i;
  end

  assign stage_wrap  = (stage_q == SW'(TW - 1));
  assign last_step_o = active_q && stage_wrap &&
                       (CW'(phase_q) == CW'(nwin_q) + CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      phase_q  <= '0;
      stage_q  <= '0;
      nwin_q   <= KW'(1);
      term_q   <= 1'b0;
    end else if (start_i && !busy_i) begin
      active_q <= 1'b1;
      phase_q  <= '0;
      stage_q  <= '0;
      nwin_q   <= nwin_clamp;
      term_q   <= term_mode_i;
    end else if (active_q) begin
      stage_q <= stage_q + SW'(1);
      if (stage_wrap) phase_q <= phase_q + PW'(1);
      if (last_step_o) active_q <= 1'b0;
    end
  end

  assign active_o = active_q;
  assign phase_o  = phase_q;
  assign stage_o  = stage_q;
  assign nwin_o   = nwin_q;
  assign term_o   = term_q;
endmodule

// File: rtl/sws_win_ctrl.sv
module sws_win_ctrl
  import sws_pkg::*;
#(
  parameter int TW      = 32,
  parameter int MAX_WIN = 16,
  parameter int SW      = $clog2(TW),
  parameter int KW      = $clog2(MAX_WIN + 1),
  parameter int PW      = $clog2(MAX_WIN + 2),
  parameter int IW      = $clog2(TW * MAX_WIN)
) (
  input  logic          active_i,
  input  logic [PW-1:0] phase_i,
  input  logic [SW-1:0] stage_i,
  input  logic [KW-1:0] nwin_i,
  input  logic          term_i,
  output logic          feed_en_o,
  output logic [IW-1:0] feed_idx_o,
  output logic          dbeta_en_o,
  output logic          dbeta_init_o,
  output logic          dbeta_term_o,
  output logic          alpha_en_o,
  output logic [IW-1:0] alpha_idx_o,
  output logic [SW-1:0] alpha_wr_addr_o,
  output logic          beta_en_o,
  output logic [IW-1:0] beta_idx_o,
  output logic          beta_load_o,
  output beta_src_e     beta_src_o,
  output logic [SW-1:0] alpha_rd_addr_o
);
  localparam int CW = (PW > KW) ? PW : KW;
  localparam int WB = IW - SW;

  logic [CW-1:0] ph, nw;
  logic [PW-1:0] a_win, b_win;
  logic [SW-1:0] lifo_addr;
  logic          first;

  assign ph    = CW'(phase_i);
  assign nw    = CW'(nwin_i);
  assign a_win = phase_i - PW'(1);
  assign b_win = phase_i - PW'(2);
  assign first = (stage_i == '0);

  // buffer direction flips each phase: read-first, same address rewritten
  assign lifo_addr = phase_i[0] ? stage_i : ~stage_i;

  always_comb begin
    feed_en_o    = active_i && (ph < nw);
    dbeta_en_o   = active_i && (ph >= CW'(1)) && (ph < nw);
    alpha_en_o   = active_i && (ph >= CW'(1)) && (ph <= nw);
    beta_en_o    = active_i && (ph >= CW'(2));
    dbeta_init_o = dbeta_en_o && first;
    dbeta_term_o = dbeta_init_o && term_i && (ph == nw - CW'(1));
    beta_load_o  = beta_en_o && first;
    beta_src_o   = (beta_en_o && (ph == nw + CW'(1))) ? BSRC_EDGE : BSRC_DUMMY;

    feed_idx_o  = feed_en_o  ? {phase_i[WB-1:0], ~stage_i} : '0;
    alpha_idx_o = alpha_en_o ? {a_win[WB-1:0], stage_i}    : '0;
    beta_idx_o  = beta_en_o  ? {b_win[WB-1:0], ~stage_i}   : '0;

    alpha_wr_addr_o = alpha_en_o ? lifo_addr : '0;
    alpha_rd_addr_o = beta_en_o  ? lifo_addr : '0;
  end
endmodule

// File: rtl/sws_llr_pipe.sv
module sws_llr_pipe #(
  parameter int IW      = 9,
  parameter int LLR_LAT = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          beta_en_i,
  input  logic [IW-1:0] beta_idx_i,
  input  logic          last_i,
  output logic          llr_valid_o,
  output logic [IW-1:0] llr_idx_o,
  output logic          pending_o,
  output logic          done_o
);
  logic [LLR_LAT-1:0] v_q, l_q;
  logic [IW-1:0]      i_q [LLR_LAT];
  logic               done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q    <= '0;
      l_q    <= '0;
      i_q[0] <= '0;
    end else begin
      v_q[0] <= beta_en_i;
      l_q[0] <= beta_en_i && last_i;
      i_q[0] <= beta_idx_i;
    end
  end

  for (genvar g = 1; g < LLR_LAT; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_q[g] <= 1'b0;
        l_q[g] <= 1'b0;
        i_q[g] <= '0;
      end else begin
        v_q[g] <= v_q[g-1];
        l_q[g] <= l_q[g-1];
        i_q[g] <= i_q[g-1];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) done_q <= 1'b0;
    else         done_q <= v_q[LLR_LAT-1] && l_q[LLR_LAT-1];
  end

  assign llr_valid_o = v_q[LLR_LAT-1];
  assign llr_idx_o   = i_q[LLR_LAT-1];
  assign pending_o   = |v_q;
  assign done_o      = done_q;
endmodule

// File: rtl/sws_ctrl.sv
module sws_ctrl
  import sws_pkg::*;
#(
  parameter int TW      = 32,
  parameter int MAX_WIN = 16,
  parameter int LLR_LAT = 2,
  localparam int SW     = $clog2(TW),
  localparam int KW     = $clog2(MAX_WIN + 1),
  localparam int PW     = $clog2(MAX_WIN + 2),
  localparam int IW     = $clog2(TW * MAX_WIN),
  localparam int LW     = $clog2((MAX_WIN + 2) * TW + LLR_LAT + 2)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [KW-1:0] num_win_i,
  input  logic          term_mode_i,
  output logic          busy_o,
  output logic          feed_en_o,
  output logic [IW-1:0] feed_idx_o,
  output logic          dbeta_en_o,
  output logic          dbeta_init_o,
  output logic          dbeta_term_o,
  output logic          alpha_en_o,
  output logic [IW-1:0] alpha_idx_o,
  output logic [SW-1:0] alpha_wr_addr_o,
  output logic          beta_en_o,
  output logic [IW-1:0] beta_idx_o,
  output logic          beta_load_o,
  output logic          beta_src_o,
  output logic [SW-1:0] alpha_rd_addr_o,
  output logic          llr_valid_o,
  output logic [IW-1:0] llr_idx_o,
  output logic          done_o,
  output logic [LW-1:0] half_len_o
);
  logic          active, term, last_step, pending;
  logic [PW-1:0] phase;
  logic [SW-1:0] stage;
  logic [KW-1:0] nwin;
  beta_src_e     bsrc;

  assign busy_o = active || pending;

  sws_phase_cnt #(.TW(TW), .MAX_WIN(MAX_WIN)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .busy_i      (busy_o),
    .num_win_i   (num_win_i),
    .term_mode_i (term_mode_i),
    .active_o    (active),
    .phase_o     (phase),
    .stage_o     (stage),
    .nwin_o      (nwin),
    .term_o      (term),
    .last_step_o (last_step)
  );

  sws_win_ctrl #(.TW(TW), .MAX_WIN(MAX_WIN)) u_win (
    .active_i        (active),
    .phase_i         (phase),
    .stage_i         (stage),
    .nwin_i          (nwin),
    .term_i          (term),
    .feed_en_o       (feed_en_o),
    .feed_idx_o      (feed_idx_o),
    .dbeta_en_o      (dbeta_en_o),
    .dbeta_init_o    (dbeta_init_o),
    .dbeta_term_o    (dbeta_term_o),
    .alpha_en_o      (alpha_en_o),
    .alpha_idx_o     (alpha_idx_o),
    .alpha_wr_addr_o (alpha_wr_addr_o),
    .beta_en_o       (beta_en_o),
    .beta_idx_o      (beta_idx_o),
    .beta_load_o     (beta_load_o),
    .beta_src_o      (bsrc),
    .alpha_rd_addr_o (alpha_rd_addr_o)
  );

  assign beta_src_o = (bsrc == BSRC_EDGE);

  sws_llr_pipe #(.IW(IW), .LLR_LAT(LLR_LAT)) u_llr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .beta_en_i   (beta_en_o),
    .beta_idx_i  (beta_idx_o),
    .last_i      (last_step),
    .llr_valid_o (llr_valid_o),
    .llr_idx_o   (llr_idx_o),
    .pending_o   (pending),
    .done_o      (done_o)
  );

  assign half_len_o = LW'((int'(nwin) + 2) * TW + LLR_LAT + 1);
endmodule

// File: rtl/sws_ctrl_chk.sv
module sws_ctrl_chk #(
  parameter int TW = 32,
  parameter int SW = 5,
  parameter int IW = 9,
  parameter int LW = 10
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          busy_o,
  input logic          feed_en_o,
  input logic [IW-1:0] feed_idx_o,
  input logic          dbeta_en_o,
  input logic          dbeta_init_o,
  input logic          dbeta_term_o,
  input logic          alpha_en_o,
  input logic [IW-1:0] alpha_idx_o,
  input logic [SW-1:0] alpha_wr_addr_o,
  input logic          beta_en_o,
  input logic          beta_load_o,
  input logic          beta_src_o,
  input logic [SW-1:0] alpha_rd_addr_o,
  input logic          llr_valid_o,
  input logic          done_o,
  input logic [LW-1:0] half_len_o
);
  p_busy_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> $stable(half_len_o));

  p_feed_desc_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (feed_en_o && $past(feed_en_o) && (feed_idx_o[SW-1:0] != SW'(TW - 1)))
      |-> (feed_idx_o == $past(feed_idx_o) - IW'(1)));

  p_alpha_asc_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alpha_en_o && $past(alpha_en_o) && (alpha_idx_o[SW-1:0] != '0))
      |-> (alpha_idx_o == $past(alpha_idx_o) + IW'(1)));

  p_dterm_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbeta_term_o |-> (dbeta_init_o && dbeta_en_o));

  p_edge_src_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beta_load_o && beta_src_o) |-> (!dbeta_en_o && !feed_en_o));

  p_lifo_addr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alpha_en_o && beta_en_o) |-> (alpha_wr_addr_o == alpha_rd_addr_o));

  p_llr_tail_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(beta_en_o) |-> llr_valid_o);

  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_after_llr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(llr_valid_o) && !busy_o));
endmodule

bind sws_ctrl sws_ctrl_chk #(.TW(TW), .SW(SW), .IW(IW), .LW(LW)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .start_i         (start_i),
  .busy_o          (busy_o),
  .feed_en_o       (feed_en_o),
  .feed_idx_o      (feed_idx_o),
  .dbeta_en_o      (dbeta_en_o),
  .dbeta_init_o    (dbeta_init_o),
  .dbeta_term_o    (dbeta_term_o),
  .alpha_en_o      (alpha_en_o),
  .alpha_idx_o     (alpha_idx_o),
  .alpha_wr_addr_o (alpha_wr_addr_o),
  .beta_en_o       (beta_en_o),
  .beta_load_o     (beta_load_o),
  .beta_src_o      (beta_src_o),
  .alpha_rd_addr_o (alpha_rd_addr_o),
  .llr_valid_o     (llr_valid_o),
  .done_o          (done_o),
  .half_len_o      (half_len_o)
);

// File: tb/sws_ctrl_tb_top.sv
module sws_ctrl_tb_top;
  localparam int TW  = 32;
  localparam int LAT = 2;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [4:0] num_win_i = '0;
  logic       term_mode_i = 1'b0;
  logic       busy_o, feed_en_o, dbeta_en_o, dbeta_init_o, dbeta_term_o;
  logic       alpha_en_o, beta_en_o, beta_load_o, beta_src_o, llr_valid_o, done_o;
  logic [8:0] feed_idx_o, alpha_idx_o, beta_idx_o, llr_idx_o;
  logic [4:0] alpha_wr_addr_o, alpha_rd_addr_o;
  logic [9:0] half_len_o;

  int checks = 0;
  int errors = 0;

  always #5 clk_i = ~clk_i;

  sws_ctrl dut_i (.*);

  // {num_win_i, term_mode, effective κ, expected half_len}
  localparam int VEC [6][4] = '{
    '{1, 0, 1, 99}, '{2, 1, 2, 131}, '{3, 0, 3, 163},
    '{5, 1, 5, 227}, '{16, 1, 16, 579}, '{16, 0, 16, 579}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_one(input int nw_in, input bit term, input int k,
                         input int exp_hl, input bit poke);
    int  s_len, p, c, m, pm, cm, hl0, done_n, ndone;
    int  mem [TW];
    bit  e_feed, e_db, e_al, e_be, e_llr;
    bit  ok_en, ok_fidx, ok_idx, ok_init, ok_load, ok_lifo, ok_llr, ok_busy;
    ok_en = 1; ok_fidx = 1; ok_idx = 1; ok_init = 1; ok_load = 1;
    ok_lifo = 1; ok_llr = 1; ok_busy = 1;
    done_n = -1; ndone = 0;
    foreach (mem[i]) mem[i] = -1;
    s_len = (k + 2) * TW;
    @(negedge clk_i);
    num_win_i = 5'(nw_in); term_mode_i = term; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    hl0 = int'(half_len_o);
    for (int n = 0; n <= s_len + LAT + 1; n++) begin
      p = n / TW; c = n % TW;
      e_feed = (n < s_len) && (p < k);
      e_db   = (n < s_len) && (p >= 1) && (p < k);
      e_al   = (n < s_len) && (p >= 1) && (p <= k);
      e_be   = (n < s_len) && (p >= 2);
      // R3 enables per phase
      if (feed_en_o != e_feed || dbeta_en_o != e_db || alpha_en_o != e_al ||
          beta_en_o != e_be) ok_en = 0;
      // R4 descending feed
      if (e_feed && int'(feed_idx_o) != p * TW + TW - 1 - c) ok_fidx = 0;
      // R5 alpha ascending, beta descending
      if (e_al && int'(alpha_idx_o) != (p - 1) * TW + c) ok_idx = 0;
      if (e_be && int'(beta_idx_o) != (p - 2) * TW + TW - 1 - c) ok_idx = 0;
      // R6 dummy init pulse and termination
      if (dbeta_init_o != (e_db && c == 0)) ok_init = 0;
      if (dbeta_term_o != (e_db && c == 0 && term && p == k - 1)) ok_init = 0;
      // R7 beta load and source
      if (beta_load_o != (e_be && c == 0)) ok_load = 0;
      if (e_be && beta_src_o != (p == k + 1)) ok_load = 0;
      // R8 read-first LIFO model
      if (beta_en_o && mem[alpha_rd_addr_o] != int'(beta_idx_o)) ok_lifo = 0;
      if (beta_en_o) mem[alpha_rd_addr_o] = -1;
      if (alpha_en_o) begin
        if (mem[alpha_wr_addr_o] != -1) ok_lifo = 0;
        mem[alpha_wr_addr_o] = int'(alpha_idx_o);
      end
      // R9 LLR strobe delayed copy of beta
      m = n - LAT; pm = (m >= 0) ? m / TW : 0; cm = (m >= 0) ? m % TW : 0;
      e_llr = (m >= 0) && (m < s_len) && (pm >= 2);
      if (llr_valid_o != e_llr) ok_llr = 0;
      if (e_llr && int'(llr_idx_o) != (pm - 2) * TW + TW - 1 - cm) ok_llr = 0;
      // R10 busy until done
      if (busy_o != (n < s_len + LAT)) ok_busy = 0;
      if (done_o) begin ndone++; done_n = n; end
      if (poke && n == TW + 3) begin start_i = 1'b1; num_win_i = 5'd7; end
      if (poke && n == TW + 5) start_i = 1'b0;
      @(negedge clk_i);
    end
    chk(ok_en,   "R3 phase enables", ok_en, 1);
    chk(ok_fidx, "R4 feed order", ok_fidx, 1);
    chk(ok_idx,  "R5 alpha/beta indices", ok_idx, 1);
    chk(ok_init, "R6 dummy init/term", ok_init, 1);
    chk(ok_load, "R7 beta load/source", ok_load, 1);
    chk(ok_lifo, "R8 alpha buffer handoff", ok_lifo, 1);
    chk(ok_llr,  "R9 llr strobe", ok_llr, 1);
    chk(ok_busy, "R10 busy window", ok_busy, 1);
    chk(ndone == 1 && done_n == s_len + LAT, "R10 done timing", done_n, s_len + LAT);
    chk(hl0 == exp_hl, "R11 half_len", hl0, exp_hl);
    chk(done_n + 1 == exp_hl, "R11 measured length", done_n + 1, exp_hl);
    if (poke) chk(int'(half_len_o) == exp_hl, "R2 start while busy ignored",
                  int'(half_len_o), exp_hl);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk(!busy_o && !done_o && !llr_valid_o && !feed_en_o && !dbeta_en_o &&
        !alpha_en_o && !beta_en_o, "R1 idle outputs", busy_o, 0);
    chk(int'(half_len_o) == 99, "R1 reset half_len", int'(half_len_o), 99);

    for (int v = 0; v < 6; v++)
      run_one(VEC[v][0], VEC[v][1] != 0, VEC[v][2], VEC[v][3], 1'b0);

    // R2 start during busy is ignored
    run_one(2, 1'b0, 2, 131, 1'b1);
    // R2 clamp: zero windows becomes one, oversize becomes the limit
    run_one(0, 1'b1, 1, 99, 1'b0);
    run_one(20, 1'b0, 16, 579, 1'b0);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule